// File: doc/BRIEF.md
# SIMD byte-load lane placement unit

This unit carries out a single-byte load for a SIMD coprocessor whose registers are 32 bits wide. It accepts one instruction word at a time and pulls four fields out of it: the destination extended register, the base general register, a signed 8-bit displacement and a 3-bit pattern selector. It reads the base register through a read port on the general register file, adds the displacement, and issues a one-byte read on a valid/ready memory request port. It then waits for the response.

When the byte returns, the unit places it in the destination register according to the pattern. It can insert the byte into one lane and keep the other three lanes. It can copy the byte into alternate halfword positions, with zero or sign fill in the lanes between. It can also broadcast the byte to all four lanes. The 16-entry extended register file lives inside the unit and has a second read port for its consumers.

When the coprocessor enable bit is clear, an instruction is accepted and completed at once, with no memory traffic and no register change.

Top module: `byte_lane_loader`

## Requirements
- R1: Field positions in the instruction word: destination register index in bits 9:6, displacement in bits 17:10, pattern in bits 20:18, base general register index in bits 25:21. All other bits are ignored.
- R2: The request address is the base register value plus the displacement read as a signed 8-bit number, taken modulo 2^32.
- R3: An instruction accepted while `cu_enable` is low raises `done` in the same cycle. It issues no memory request and leaves the extended register file unchanged.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address does not change.
- R5: Patterns 0, 1, 2 and 3 write the byte into bits 7:0, 15:8, 23:16 and 31:24 respectively. The other 24 bits keep their previous contents.
- R6: Pattern 4 writes {8'h00, b, 8'h00, b}. Pattern 5 writes {b, 8'h00, b, 8'h00}.
- R7: Pattern 6 writes {s, b, s, b}, where s is eight copies of bit 7 of the byte.
- R8: Pattern 7 writes the byte into all four lanes.
- R9: For an enabled instruction, `done` is high for exactly the one cycle in which `mem_rsp_valid` is seen after the request. The register write takes effect at the end of that cycle.
- R10: `instr_ready` is low from the cycle after an enabled instruction is accepted up to and including its `done` cycle.
- R11: A synchronous active-high reset clears all 16 extended registers to zero and returns the unit to idle, with `instr_ready` high and `mem_req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cu_enable | input | 1 | Enable bit of the coprocessor control register |
| instr_valid | input | 1 | An instruction word is offered |
| instr_ready | output | 1 | Unit is idle and takes the offered instruction |
| instr_word | input | 32 | Instruction word |
| gpr_raddr | output | 5 | Base register index, derived from `instr_word` |
| gpr_rdata | input | 32 | Base register value (combinational read) |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Loaded byte |
| done | output | 1 | Instruction completes this cycle |
| xr_rd_idx | input | 4 | Extended register read index |
| xr_rd_data | output | 32 | Extended register read data |

## Verification
The assertions watch the protocol side on every cycle. They check the address formed for each accepted enabled instruction, the stability of a stalled request, the absence of a request after a suppressed instruction, the blocking of new instructions while a load is in flight, and the lane shape of the broadcast and sign-fill writes. Preserving the untouched lanes under the insert patterns, leaving the register file unchanged when execution is suppressed, and clearing the file at reset can only be shown by the bench. It reads registers back through the read port after loads against a model of the register file.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

   typedef enum logic [2:0] {
      PAT_INS0     = 3'd0,
      PAT_INS1     = 3'd1,
      PAT_INS2     = 3'd2,
      PAT_INS3     = 3'd3,
      PAT_DUP_ZLO  = 3'd4,
      PAT_DUP_ZHI  = 3'd5,
      PAT_DUP_SEXT = 3'd6,
      PAT_SPLAT    = 3'd7
   } sbl_pat_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } sbl_state_e;

   typedef struct packed {
      logic [4:0] base_idx;
      sbl_pat_e   pat;
      logic [7:0] disp;
      logic [3:0] dst_idx;
   } sbl_dec_t;

endpackage

// File: rtl/sbl_decode.sv
module sbl_decode
   import sbl_pkg::*;
#(
   parameter int IW = 32
) (
   input  logic [IW-1:0] instr,
   output sbl_dec_t      dec
);
   if (IW < 26) begin : g_bad_iw
      $error("sbl_decode: instruction width too small for field layout");
   end

   // R1: field extraction
   always_comb begin
      dec.dst_idx  = instr[9:6];
      dec.disp     = instr[17:10];
      dec.pat      = sbl_pat_e'(instr[20:18]);
      dec.base_idx = instr[25:21];
   end
endmodule

// File: rtl/sbl_lane_merge.sv
module sbl_lane_merge
   import sbl_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int W     = LANE_W * LANES
) (
   input  sbl_pat_e          pat,
   input  logic [LANE_W-1:0] ld_byte,
   input  logic [W-1:0]      old_val,
   output logic [W-1:0]      new_val
);
   if (LANES != 4) begin : g_bad_lanes
      $error("sbl_lane_merge: pattern encoding needs exactly four lanes");
   end

   logic [LANE_W-1:0] sfill;
   assign sfill = {LANE_W{ld_byte[LANE_W-1]}};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [1:0] IDX = 2'(i);
      localparam bit         ODD = (i % 2) == 1;
      logic [LANE_W-1:0] lane_v;

      always_comb begin
         unique case (pat)
            PAT_INS0, PAT_INS1, PAT_INS2, PAT_INS3:
               lane_v = (pat[1:0] == IDX) ? ld_byte : old_val[i*LANE_W +: LANE_W];
            PAT_DUP_ZLO:  lane_v = ODD ? '0 : ld_byte;
            PAT_DUP_ZHI:  lane_v = ODD ? ld_byte : '0;
            PAT_DUP_SEXT: lane_v = ODD ? sfill : ld_byte;
            default:      lane_v = ld_byte;
         endcase
      end

      assign new_val[i*LANE_W +: LANE_W] = lane_v;
   end
endmodule

// File: rtl/sbl_xregfile.sv
module sbl_xregfile #(
   parameter int DEPTH = 16,
   parameter int W     = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [W-1:0]  rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_b
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("sbl_xregfile: depth must be at least two");
   end

   logic [W-1:0] regs [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (rst)
            regs[e] <= '0;
         else if (we && (waddr == AW'(e)))
            regs[e] <= wdata;
      end
   end

   assign rdata_a = regs[raddr_a];
   assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/byte_lane_loader.sv
module byte_lane_loader
   import sbl_pkg::*;
#(
   parameter int IW       = 32,
   parameter int ADDR_W   = 32,
   parameter int LANE_W   = 8,
   parameter int LANES    = 4,
   parameter int XR_DEPTH = 16,
   localparam int XW      = LANE_W * LANES,
   localparam int XAW     = $clog2(XR_DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cu_enable,
   input  logic              instr_valid,
   output logic              instr_ready,
   input  logic [IW-1:0]     instr_word,
   output logic [4:0]        gpr_raddr,
   input  logic [ADDR_W-1:0] gpr_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [LANE_W-1:0] mem_rsp_data,
   output logic              done,
   input  logic [XAW-1:0]    xr_rd_idx,
   output logic [XW-1:0]     xr_rd_data
);
   if ((1 << XAW) != XR_DEPTH || XAW != 4) begin : g_bad_xr
      $error("byte_lane_loader: register file must match 4-bit index field");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("byte_lane_loader: address narrower than displacement");
   end

   sbl_dec_t   dec;
   sbl_state_e state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [XAW-1:0]    dst_q;
   sbl_pat_e          pat_q;
   logic              accept, xr_we;
   logic [XW-1:0]     old_val, new_val;

   sbl_decode #(.IW(IW)) i_dec (.instr(instr_word), .dec(dec));

   assign gpr_raddr   = dec.base_idx;
   assign instr_ready = (state_q == ST_IDLE);
   assign accept      = instr_valid && instr_ready;
   assign xr_we       = (state_q == ST_WAIT) && mem_rsp_valid;
   assign done        = (accept && !cu_enable) || xr_we;

   assign mem_req_valid = (state_q == ST_REQ);
   assign mem_req_addr  = addr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         dst_q   <= '0;
         pat_q   <= PAT_INS0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept && cu_enable) begin
               addr_q  <= gpr_rdata + {{(ADDR_W-8){dec.disp[7]}}, dec.disp};
               dst_q   <= dec.dst_idx;
               pat_q   <= dec.pat;
               state_q <= ST_REQ;
            end
            ST_REQ:  if (mem_req_ready) state_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   sbl_lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) i_merge (
      .pat     (pat_q),
      .ld_byte (mem_rsp_data),
      .old_val (old_val),
      .new_val (new_val)
   );

   sbl_xregfile #(.DEPTH(XR_DEPTH), .W(XW)) i_xrf (
      .clk     (clk),
      .rst     (rst),
      .we      (xr_we),
      .waddr   (dst_q),
      .wdata   (new_val),
      .raddr_a (dst_q),
      .rdata_a (old_val),
      .raddr_b (xr_rd_idx),
      .rdata_b (xr_rd_data)
   );

   // R2: address formed from the port values seen at acceptance
   a_r2_addr_formed: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr_ready && cu_enable) |=>
         (mem_req_addr == $past(gpr_rdata + {{(ADDR_W-8){instr_word[17]}}, instr_word[17:10]})));

   // R3: suppressed instruction issues no request
   a_r3_no_req_disabled: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr_ready && !cu_enable) |=> !mem_req_valid);

   // R4: stalled request holds
   a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R10: no instruction taken while a load is outstanding
   a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
      mem_req_valid |-> !instr_ready);

   // R9: done only from a write or a suppressed acceptance
   a_r9_done_source: assert property (@(posedge clk) disable iff (rst)
      done |-> (mem_rsp_valid || (instr_valid && !cu_enable)));

   // R7: sign fill lanes follow the byte's top bit
   a_r7_sign_fill: assert property (@(posedge clk) disable iff (rst)
      (xr_we && pat_q == PAT_DUP_SEXT) |->
         (new_val[31:24] == {8{mem_rsp_data[7]}} && new_val[15:8] == {8{mem_rsp_data[7]}}));

   // R8: broadcast puts the same byte everywhere
   a_r8_splat: assert property (@(posedge clk) disable iff (rst)
      (xr_we && pat_q == PAT_SPLAT) |->
         (new_val == {LANES{mem_rsp_data}}));
endmodule

// File: tb/test_byte_lane_loader.sv
module test_byte_lane_loader;
   logic        clk = 1'b0;
   logic        rst;
   logic        cu_enable;
   logic        instr_valid;
   logic        instr_ready;
   logic [31:0] instr_word;
   logic [4:0]  gpr_raddr;
   logic [31:0] gpr_rdata;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [7:0]  mem_rsp_data;
   logic        done;
   logic [3:0]  xr_rd_idx;
   logic [31:0] xr_rd_data;

   int checks = 0;
   int errors = 0;
   logic [31:0] gprs   [32];
   logic [31:0] exp_xr [16];

   always #4 clk = ~clk;

   byte_lane_loader i_byte_lane_loader (
      .clk(clk), .rst(rst), .cu_enable(cu_enable),
      .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
      .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .xr_rd_idx(xr_rd_idx), .xr_rd_data(xr_rd_data)
   );

   always_comb gpr_rdata = gprs[gpr_raddr];

   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24];
   endfunction

   function automatic logic [31:0] mk_instr(input logic [3:0] d, input logic [7:0] off,
                                            input logic [2:0] p, input logic [4:0] b,
                                            input logic [5:0] hi, input logic [5:0] lo);
      return {hi, b, p, off, d, lo};
   endfunction

   function automatic logic [31:0] place(input logic [2:0] p, input logic [7:0] b,
                                         input logic [31:0] old);
      logic [7:0] s = {8{b[7]}};
      case (p)
         3'd0:    return {old[31:8], b};
         3'd1:    return {old[31:16], b, old[7:0]};
         3'd2:    return {old[31:24], b, old[15:0]};
         3'd3:    return {b, old[23:0]};
         3'd4:    return {8'h00, b, 8'h00, b};
         3'd5:    return {b, 8'h00, b, 8'h00};
         3'd6:    return {s, b, s, b};
         default: return {b, b, b, b};
      endcase
   endfunction

   function automatic string pat_req(input logic [2:0] p);
      if (p < 3'd4) return "R5";
      if (p < 3'd6) return "R6";
      if (p == 3'd6) return "R7";
      return "R8";
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic exec(input logic [31:0] iw, input logic en);
      logic [3:0]  d     = iw[9:6];
      logic [2:0]  p     = iw[20:18];
      logic [31:0] eaddr = gprs[iw[25:21]] + {{24{iw[17]}}, iw[17:10]};
      logic [31:0] old   = exp_xr[d];
      logic        hs    = 1'b0;
      @(negedge clk);
      instr_word  = iw;
      cu_enable   = en;
      instr_valid = 1'b1;
      #1;
      if (!en) begin
         chk("R3 done at accept", {31'd0, done}, 32'd1);
         @(negedge clk);
         instr_valid = 1'b0;
         xr_rd_idx   = d;
         #1;
         chk("R3 no request", {31'd0, mem_req_valid}, 32'd0);
         chk("R3 register unchanged", xr_rd_data, old);
      end else begin
         chk("R9 no done at accept", {31'd0, done}, 32'd0);
         @(negedge clk);
         instr_valid = 1'b0;
         #1;
         chk("R10 busy after accept", {31'd0, instr_ready}, 32'd0);
         for (int g = 0; g < 50 && !hs; g++) begin
            mem_req_ready = ($urandom % 3) != 0;
            #1;
            if (mem_req_valid && mem_req_ready) begin
               hs = 1'b1;
               chk("R1 R2 address", mem_req_addr, eaddr);
            end
            @(negedge clk);
         end
         mem_req_ready = 1'b0;
         if (!hs) chk("R4 request handshake", 32'd0, 32'd1);
         for (int w = 0; w < int'($urandom % 4); w++) begin
            #1;
            chk("R9 no early done", {31'd0, done}, 32'd0);
            @(negedge clk);
         end
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = mem_byte(eaddr);
         #1;
         chk("R9 done with response", {31'd0, done}, 32'd1);
         chk("R10 busy at done", {31'd0, instr_ready}, 32'd0);
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         xr_rd_idx     = d;
         exp_xr[d]     = place(p, mem_byte(eaddr), old);
         #1;
         chk("R9 single pulse", {31'd0, done}, 32'd0);
         chk(pat_req(p), xr_rd_data, exp_xr[d]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 32; i++) gprs[i] = $urandom;
      gprs[1] = 32'h0000_0080;
      gprs[2] = 32'h0000_007F;
      gprs[3] = 32'hFFFF_FFFF;
      gprs[4] = 32'h0000_0100;
      for (int i = 0; i < 16; i++) exp_xr[i] = '0;
      rst = 1'b1; cu_enable = 1'b1; instr_valid = 1'b0; instr_word = '0;
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; xr_rd_idx = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R11 idle ready", {31'd0, instr_ready}, 32'd1);
      chk("R11 no request", {31'd0, mem_req_valid}, 32'd0);
      for (int i = 0; i < 16; i++) begin
         xr_rd_idx = 4'(i);
         #1;
         chk("R11 register cleared", xr_rd_data, 32'd0);
      end

      // directed: preset register 5 with a broadcast, then each pattern on top
      for (int p = 0; p < 8; p++) begin
         exec(mk_instr(4'd5, 8'h25, 3'd7, 5'd1, 6'h3F, 6'h15), 1'b1); // byte 0xA5
         exec(mk_instr(4'd5, 8'h00, 3'(p), 5'd1, 6'h00, 6'h00), 1'b1); // byte 0x80
         exec(mk_instr(4'd6, 8'h00, 3'(p), 5'd2, 6'h00, 6'h00), 1'b1); // byte 0x7F
      end
      // negative displacement and address wrap
      exec(mk_instr(4'd7, 8'h80, 3'd6, 5'd4, 6'h00, 6'h00), 1'b1);
      exec(mk_instr(4'd8, 8'h01, 3'd7, 5'd3, 6'h00, 6'h00), 1'b1);
      // suppressed instructions on a loaded register
      exec(mk_instr(4'd5, 8'h10, 3'd7, 5'd1, 6'h00, 6'h00), 1'b0);
      exec(mk_instr(4'd7, 8'hF0, 3'd0, 5'd9, 6'h2A, 6'h01), 1'b0);

      for (int n = 0; n < 300; n++) begin
         exec(mk_instr(4'($urandom), 8'($urandom), 3'($urandom), 5'($urandom),
                       6'($urandom), 6'($urandom)), ($urandom % 8) != 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule